// File: doc/BRIEF.md
# Accumulator Instruction Executor

This block runs one-address instructions against a private accumulator. Each 8-bit instruction word holds an operation and one store location. The accumulator is always the hidden first source and the hidden destination. A 16-entry operand store holds the other operands. Explicit load and store operations move values between the accumulator and the store. Arithmetic covers add, subtract, multiply and unsigned divide, and all of it wraps to the data width. A divide by zero produces all ones and sets an error flag. The flag stays set until reset.

The block does not fetch instructions or branch. A sequencer outside the block presents one instruction word together with a valid strobe. The block returns a one-cycle done pulse once the result is in place. The accumulator is always visible on an output. A combinational debug port reads any store location, so software and testbenches can see the results of store operations.

The controller has three states. IDLE waits for work. EXEC evaluates the latched instruction and commits its result at the end of the cycle. FIN signals done.
- IDLE→EXEC takes place when valid is seen. Otherwise IDLE→IDLE.
- EXEC→FIN takes place always.
- FIN→EXEC takes place when a new valid is seen, which gives back-to-back execution. Otherwise FIN→IDLE.

Top module: `acc_exec_core`

## Requirements
- R1: After reset the accumulator reads 0, the error flag and done are low, and store location k reads the value k on the debug port.
- R2: The instruction word carries the operation code in bits [7:4] and the store location in bits [3:0].
- R3: Code 0 adds the location to the accumulator. Code 1 computes accumulator minus location. Code 2 multiplies and keeps the low 16 bits. All three wrap modulo 2^16.
- R4: Code 3 replaces the accumulator with the unsigned quotient of the accumulator divided by a nonzero location.
- R5: Code 3 with a zero operand sets the accumulator to 0xFFFF and sets the error flag. The flag then stays high until reset.
- R6: Code 4 copies the location into the accumulator.
- R7: Code 5 writes the accumulator into the location and leaves the accumulator unchanged. The debug port shows the new value afterwards.
- R8: Codes 6 to 15 change neither the accumulator nor the store, but they still produce done.
- R9: Valid is sampled on a rising edge. Done is high for exactly one cycle, in the second cycle after the accepting edge, and the new accumulator value shows in that same cycle. The accumulator changes in no other cycle.
- R10: A valid in the cycle right after acceptance is ignored. A valid in the done cycle is accepted, so instructions can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word is present |
| instr_word | input | 8 | Operation [7:4], location [3:0] |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 16 | Accumulator value |
| div_err | output | 1 | Sticky divide-by-zero flag |
| dbg_addr | input | 4 | Debug read location |
| dbg_data | output | 16 | Contents of the debug location |

## Verification
The assertions assume that the sequencer raises valid only when the block can accept it, or that an ignored strobe is really meant to be dropped. They also assume that the debug port never disturbs execution. The driver raises valid only in idle or done cycles, except for one deliberate stray strobe during EXEC. The scoreboard counts exactly one expected done for every accepted word, so any extra pulse from that stray strobe is caught.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD  = 4'd0,
        OPC_SUB  = 4'd1,
        OPC_MUL  = 4'd2,
        OPC_DIV  = 4'd3,
        OPC_LOAD = 4'd4,
        OPC_SAVE = 4'd5
    } opcode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_FIN  = 2'd2
    } exec_state_e;

endpackage

// File: rtl/acc_exec_store.sv
module acc_exec_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Each cell comes out of reset holding its own index.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= DATA_W'(g);
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                cells[g] <= wr_data;
            end
        end
    end

    assign rd_data  = cells[rd_addr];
    assign dbg_data = cells[dbg_addr];

endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
    import acc_exec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [DATA_W-1:0] acc_q,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_d,
    output logic              acc_we,
    output logic              mem_we,
    output logic              div_zero
);
    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] product;
    logic              opnd_zero;
    opcode_e           op;

    assign op        = opcode_e'(opc);
    assign product   = {{DATA_W{1'b0}}, acc_q} * {{DATA_W{1'b0}}, operand};
    assign opnd_zero = (operand == '0);

    always_comb begin
        acc_d    = acc_q;
        acc_we   = 1'b0;
        mem_we   = 1'b0;
        div_zero = 1'b0;
        unique case (op)
            OPC_ADD: begin
                acc_d  = acc_q + operand;
                acc_we = 1'b1;
            end
            OPC_SUB: begin
                acc_d  = acc_q - operand;
                acc_we = 1'b1;
            end
            OPC_MUL: begin
                acc_d  = product[DATA_W-1:0];
                acc_we = 1'b1;
            end
            OPC_DIV: begin
                acc_we = 1'b1;
                if (opnd_zero) begin
                    acc_d    = '1;
                    div_zero = 1'b1;
                end else begin
                    acc_d = acc_q / operand;
                end
            end
            OPC_LOAD: begin
                acc_d  = operand;
                acc_we = 1'b1;
            end
            OPC_SAVE: begin
                mem_we = 1'b1;
            end
            default: begin
                acc_d = acc_q;
            end
        endcase
    end

endmodule

// File: rtl/acc_exec_fsm.sv
module acc_exec_fsm
    import acc_exec_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    output logic              accept,
    output logic              exec_en,
    output logic              done,
    output logic [WORD_W-1:0] cur_word
);
    exec_state_e state_q;
    exec_state_e state_d;
    logic        can_take;

    assign can_take = (state_q == ST_IDLE) || (state_q == ST_FIN);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Instruction latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_word <= '0;
        end else if (accept) begin
            cur_word <= instr_word;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = instr_valid ? ST_EXEC : ST_IDLE;
            ST_EXEC: state_d = ST_FIN;
            ST_FIN:  state_d = instr_valid ? ST_EXEC : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept  = instr_valid && can_take;
        exec_en = (state_q == ST_EXEC);
        done    = (state_q == ST_FIN);
    end

endmodule

// File: rtl/acc_exec_core.sv
module acc_exec_core
    import acc_exec_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    instr_valid,
    input  logic [OPC_W+ADDR_W-1:0] instr_word,
    output logic                    done,
    output logic [DATA_W-1:0]       acc_out,
    output logic                    div_err,
    input  logic [ADDR_W-1:0]       dbg_addr,
    output logic [DATA_W-1:0]       dbg_data
);
    localparam int WORD_W = OPC_W + ADDR_W;

    logic              accept;
    logic              exec_en;
    logic [WORD_W-1:0] cur_word;
    logic [OPC_W-1:0]  cur_op_raw;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_d;
    logic              acc_we;
    logic              mem_we;
    logic              div_zero;
    logic              err_q;

    assign cur_op_raw = cur_word[WORD_W-1:ADDR_W];
    assign cur_addr   = cur_word[ADDR_W-1:0];

    acc_exec_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .accept      (accept),
        .exec_en     (exec_en),
        .done        (done),
        .cur_word    (cur_word)
    );

    acc_exec_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (exec_en && mem_we),
        .wr_addr  (cur_addr),
        .wr_data  (acc_q),
        .rd_addr  (cur_addr),
        .rd_data  (operand),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    acc_exec_alu #(.DATA_W(DATA_W)) u_alu (
        .opc      (cur_op_raw),
        .acc_q    (acc_q),
        .operand  (operand),
        .acc_d    (acc_d),
        .acc_we   (acc_we),
        .mem_we   (mem_we),
        .div_zero (div_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            err_q <= 1'b0;
        end else if (exec_en) begin
            if (acc_we) acc_q <= acc_d;
            if (div_zero) err_q <= 1'b1;
        end
    end

    assign acc_out = acc_q;
    assign div_err = err_q;

endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              accept,
    input logic              div_err,
    input logic [DATA_W-1:0] acc_out,
    input logic [3:0]        cur_op
);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!done ##1 done));

    // R9
    acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_out) |-> done);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |=> div_err);

    // R5
    err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_err) |-> (done && (acc_out == {DATA_W{1'b1}})));

    // R7
    save_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cur_op == 4'd5)) |-> $stable(acc_out));

    // R8
    nop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cur_op > 4'd5)) |-> $stable(acc_out));
endmodule

bind acc_exec_core acc_exec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .accept  (accept),
    .div_err (div_err),
    .acc_out (acc_out),
    .cur_op  (cur_op_raw)
);

// File: tb/test_acc_exec_core.sv
`timescale 1ns/1ps
module test_acc_exec_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [7:0]  instr_word = '0;
    logic        done;
    logic [15:0] acc_out;
    logic        div_err;
    logic [3:0]  dbg_addr = '0;
    logic [15:0] dbg_data;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_acc = '0;
    logic        m_err = 1'b0;
    logic [15:0] m_mem [16];

    logic [15:0] q_acc [$];
    logic        q_err [$];
    string       q_req [$];

    always #2 clk = ~clk;

    acc_exec_core i_acc_exec_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .done        (done),
        .acc_out     (acc_out),
        .div_err     (div_err),
        .dbg_addr    (dbg_addr),
        .dbg_data    (dbg_data)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Driver: model the instruction, queue the expectation, then drive it (R2 field layout)
    task automatic issue(logic [3:0] opc, logic [3:0] loc, string req);
        logic [15:0] opnd;
        opnd = m_mem[loc];
        case (opc)
            4'd0: m_acc = m_acc + opnd;
            4'd1: m_acc = m_acc - opnd;
            4'd2: m_acc = 16'((32'(m_acc) * 32'(opnd)) & 32'hFFFF);
            4'd3: if (opnd == 0) begin m_acc = 16'hFFFF; m_err = 1'b1; end
                  else m_acc = m_acc / opnd;
            4'd4: m_acc = opnd;
            4'd5: m_mem[loc] = m_acc;
            default: ;
        endcase
        q_acc.push_back(m_acc);
        q_err.push_back(m_err);
        q_req.push_back(req);
        instr_word  = {opc, loc};
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare every done against the head of the queue (R9)
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_acc.size() == 0) begin
                chk("R9 unexpected done", 32'(done), 32'd0);
            end else begin
                string r;
                logic [15:0] ea;
                logic        ee;
                r  = q_req.pop_front();
                ea = q_acc.pop_front();
                ee = q_err.pop_front();
                chk(r, 32'(acc_out), 32'(ea));
                chk({r, " err"}, 32'(div_err), 32'(ee));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk("R9 watchdog", 32'd1, 32'd0);
        summary();
    end

    initial begin
        for (int k = 0; k < 16; k++) m_mem[k] = 16'(k);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 acc", 32'(acc_out), 32'd0);
        chk("R1 err", 32'(div_err), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        for (int k = 0; k < 16; k++) begin
            dbg_addr = 4'(k);
            #0.1;
            chk("R1 preset", 32'(dbg_data), 32'(k));
        end
        rst_n = 1'b1;
        @(negedge clk);

        issue(4'd4, 4'd7,  "R6 load");
        issue(4'd0, 4'd9,  "R3 add");
        issue(4'd2, 4'd15, "R3 mul");
        issue(4'd1, 4'd3,  "R3 sub");
        issue(4'd5, 4'd2,  "R7 save keeps acc");
        dbg_addr = 4'd2;
        #0.1;
        chk("R7 save written", 32'(dbg_data), 32'd237);
        issue(4'd2, 4'd2,  "R3 mul square");
        issue(4'd2, 4'd2,  "R3 mul wrap");
        issue(4'd4, 4'd0,  "R6 load zero");
        issue(4'd1, 4'd1,  "R3 sub wrap");
        issue(4'd3, 4'd5,  "R4 divide");
        issue(4'd9, 4'd2,  "R8 nop");
        issue(4'd15, 4'd4, "R8 nop high");
        #0.1;
        chk("R8 store untouched", 32'(dbg_data), 32'd237);

        // Gap, then R10: a stray valid during EXEC is dropped
        repeat (2) @(negedge clk);
        chk("R9 idle done low", 32'(done), 32'd0);
        instr_word  = {4'd0, 4'd6};
        instr_valid = 1'b1;
        m_acc = m_acc + m_mem[6];
        q_acc.push_back(m_acc); q_err.push_back(m_err); q_req.push_back("R10 accepted");
        @(negedge clk);
        instr_word  = {4'd4, 4'd15};
        @(negedge clk);
        instr_valid = 1'b0;
        @(negedge clk);
        chk("R10 stray ignored", 32'(done), 32'd0);
        chk("R10 acc held", 32'(acc_out), 32'(m_acc));

        issue(4'd3, 4'd0,  "R5 div zero");
        issue(4'd4, 4'd4,  "R5 sticky after load");
        issue(4'd5, 4'd11, "R7 save again");
        dbg_addr = 4'd11;
        #0.1;
        chk("R7 save visible", 32'(dbg_data), 32'd4);
        issue(4'd3, 4'd11, "R4 divide self");

        repeat (4) @(negedge clk);
        chk("R9 all done seen", 32'(q_acc.size()), 32'd0);
        summary();
    end
endmodule